// File: doc/BRIEF.md
# Common-Line Scan Token Register

This block produces the row scan for a 64-row passive-matrix LCD. A single active token steps across the common lines, one line per period of the line clock CL, and every line gets a 2-bit code that tells the analog driver which of four bias levels to apply. The code depends on whether the line holds the token and on the frame-alternation polarity M. The scan can run in either direction, and the line-clock edge that starts a period can be chosen.

Two copies can be chained to scan more rows. The master makes its own token from a frame-start pulse. The slave takes the token from its neighbour through one of two data pins. Which pin is the input and which is the output depends on the scan direction. The last line of the master passes the token to the first line of the slave. The design runs from a fast system clock and samples CL as a data input. Reset is synchronous and active high.

Top module: `lcs_com_scan`

## Requirements
- R1: Synchronous reset clears the token. While reset is held, and afterwards until a new token arrives, every line code is 01 when M=0 and both DIO outputs are 0.
- R2: With `shl`=1, a token entered at an active CL edge sits on line 0 for that CL period. Each later active edge moves it up by one line, through line NCOM-1.
- R3: With `shl`=0, the token enters at line NCOM-1 and each active edge moves it down by one line, through line 0.
- R4: The active edge is the rising edge of `cl` when `psel`=1 and the falling edge when `psel`=0. The opposite edge never moves the token, and neither does a cycle in which `cl` is unchanged.
- R5: Each line code is a function of the M value from the previous system clock and of whether that line holds the token:

  | M | Line holds token | Code | Level |
  |---|------------------|------|-------|
  | 0 | no               | 01   | V1    |
  | 0 | yes              | 11   | V5    |
  | 1 | no               | 10   | V4    |
  | 1 | yes              | 00   | V0    |
- R6: In master role (`is_master`=1), both DIO output enables are 1 and the DIO inputs are ignored. A 1 on `frame_start` at an active edge enters the token. Both DIO outputs are 1 exactly during the CL period in which the last line of the scan holds the token.
- R7: In slave role with `shl`=1, `dio1` is the input: `dio1_oe`=0, `dio2_oe`=1, and `dio2_in` is ignored. With `shl`=0 the roles swap: `dio1_oe`=1, `dio2_oe`=0, and `dio1_in` is ignored.
- R8: In slave role, the selected DIO input is sampled at each active edge and shifted in as the new first-line value; `frame_start` is ignored. In a chain, the slave's first line is active in the CL period right after the master's last line.
- R9: A token that moves past the last line is dropped and does not wrap around. If no new token is entered, every line goes inactive and stays inactive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; `cl` is sampled on it |
| rst | input | 1 | Synchronous active-high reset |
| cl | input | 1 | Line clock; one period per common line |
| m_pol | input | 1 | Frame-alternation polarity M |
| shl | input | 1 | Scan direction: 1 = upward from line 0, 0 = downward |
| psel | input | 1 | Active CL edge: 1 = rising, 0 = falling |
| is_master | input | 1 | 1 = master role, 0 = slave role |
| frame_start | input | 1 | Frame-start level, sampled at the active edge (master only) |
| dio1_in | input | 1 | Token input on pin 1 (slave with shl=1) |
| dio2_in | input | 1 | Token input on pin 2 (slave with shl=0) |
| dio1_out | output | 1 | Token output, pin 1 |
| dio1_oe | output | 1 | Output enable, pin 1 |
| dio2_out | output | 1 | Token output, pin 2 |
| dio2_oe | output | 1 | Output enable, pin 2 |
| lvl_codes | output | 2*NCOM | Level code of line i in bits [2i+1:2i] |

## Verification
An active CL edge becomes visible to the design at the next system clock edge. At that edge the token register and the DIO outputs update, and the line codes follow one clock later. A change on M alone reaches the codes after one clock. The bench changes inputs on falling system-clock edges and waits four clocks after every CL transition before it samples. Each CL period is sampled twice: once after the active edge and once after the inactive edge. A token that moved on the wrong edge therefore shows up as a one-line offset in the first sample.

// File: rtl/lcs_pkg.sv
package lcs_pkg;

  typedef enum logic [1:0] {
    LVL_V0 = 2'b00,
    LVL_V1 = 2'b01,
    LVL_V4 = 2'b10,
    LVL_V5 = 2'b11
  } lvl_t;

  // Bias level for one line from frame polarity and token presence.
  function automatic lvl_t pick_level(input logic frame_pol, input logic selected);
    case ({frame_pol, selected})
      2'b00:   return LVL_V1;
      2'b01:   return LVL_V5;
      2'b10:   return LVL_V4;
      default: return LVL_V0;
    endcase
  endfunction

endpackage

// File: rtl/lcs_cl_edge.sv
module lcs_cl_edge (
  input  logic clk,
  input  logic rst,
  input  logic cl,
  input  logic psel,
  output logic step
);

  logic cl_q;

  always_ff @(posedge clk) begin
    if (rst) cl_q <= cl;
    else     cl_q <= cl;
  end

  // Rising edge when psel=1, falling edge otherwise.
  assign step = psel ? (cl & ~cl_q) : (~cl & cl_q);

endmodule

// File: rtl/lcs_token_shift.sv
module lcs_token_shift #(
  parameter int NCOM = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            step,
  input  logic            shl,
  input  logic            shift_in,
  output logic [NCOM-1:0] tok
);

  localparam int LAST = NCOM - 1;

  logic [NCOM-1:0] nxt;

  // Each position takes its lower neighbour when scanning up, its upper neighbour when scanning down.
  for (genvar i = 0; i < NCOM; i++) begin : g_pos
    logic from_low;
    logic from_high;
    if (i == 0) begin : g_first
      assign from_low = shift_in;
    end else begin : g_mid_low
      assign from_low = tok[i-1];
    end
    if (i == LAST) begin : g_last
      assign from_high = shift_in;
    end else begin : g_mid_high
      assign from_high = tok[i+1];
    end
    assign nxt[i] = shl ? from_low : from_high;
  end

  always_ff @(posedge clk) begin
    if (rst)       tok <= '0;
    else if (step) tok <= nxt;
  end

endmodule

// File: rtl/lcs_level_enc.sv
module lcs_level_enc
  import lcs_pkg::*;
#(
  parameter int NCOM = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              m_pol,
  input  logic [NCOM-1:0]   tok,
  output logic [2*NCOM-1:0] codes
);

  always_ff @(posedge clk) begin
    for (int i = 0; i < NCOM; i++) begin
      if (rst) codes[2*i +: 2] <= LVL_V1;
      else     codes[2*i +: 2] <= pick_level(m_pol, tok[i]);
    end
  end

endmodule

// File: rtl/lcs_com_scan.sv
module lcs_com_scan #(
  parameter int NCOM = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cl,
  input  logic              m_pol,
  input  logic              shl,
  input  logic              psel,
  input  logic              is_master,
  input  logic              frame_start,
  input  logic              dio1_in,
  input  logic              dio2_in,
  output logic              dio1_out,
  output logic              dio1_oe,
  output logic              dio2_out,
  output logic              dio2_oe,
  output logic [2*NCOM-1:0] lvl_codes
);

  localparam int LAST = NCOM - 1;

  logic            step;
  logic            shift_in;
  logic            carry;
  logic [NCOM-1:0] tok;

  lcs_cl_edge u_edge (
    .clk  (clk),
    .rst  (rst),
    .cl   (cl),
    .psel (psel),
    .step (step)
  );

  // The master enters its own token; the slave takes it from the pin facing upstream.
  assign shift_in = is_master ? frame_start : (shl ? dio1_in : dio2_in);

  lcs_token_shift #(.NCOM(NCOM)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .step     (step),
    .shl      (shl),
    .shift_in (shift_in),
    .tok      (tok)
  );

  lcs_level_enc #(.NCOM(NCOM)) u_enc (
    .clk   (clk),
    .rst   (rst),
    .m_pol (m_pol),
    .tok   (tok),
    .codes (lvl_codes)
  );

  // The token on the last scanned position goes out to the next device.
  assign carry    = shl ? tok[LAST] : tok[0];
  assign dio1_out = carry;
  assign dio2_out = carry;
  assign dio1_oe  = is_master | ~shl;
  assign dio2_oe  = is_master | shl;

endmodule

// File: rtl/lcs_com_scan_chk.sv
module lcs_com_scan_chk #(
  parameter int NCOM = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              cl,
  input logic              m_pol,
  input logic              shl,
  input logic              is_master,
  input logic              dio1_oe,
  input logic              dio2_oe,
  input logic [2*NCOM-1:0] lvl_codes,
  input logic [NCOM-1:0]   tok
);

  logic [NCOM-1:0] low_bits;
  logic [NCOM-1:0] high_bits;

  always_comb begin
    for (int i = 0; i < NCOM; i++) begin
      low_bits[i]  = lvl_codes[2*i];
      high_bits[i] = lvl_codes[2*i+1];
    end
  end

  // R4
  no_edge_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $stable(cl) |=> $stable(tok));

  // R5
  pol_bit_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (low_bits == {NCOM{~$past(m_pol)}}));

  // R5
  sel_bit_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (high_bits == ($past(tok) ^ {NCOM{$past(m_pol)}})));

  // R6
  master_oe_chk: assert property (@(posedge clk) disable iff (rst)
    is_master |-> (dio1_oe && dio2_oe));

  // R7
  slave_up_oe_chk: assert property (@(posedge clk) disable iff (rst)
    (!is_master && shl) |-> (!dio1_oe && dio2_oe));

  // R7
  slave_down_oe_chk: assert property (@(posedge clk) disable iff (rst)
    (!is_master && !shl) |-> (dio1_oe && !dio2_oe));

endmodule

bind lcs_com_scan lcs_com_scan_chk #(.NCOM(NCOM)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cl        (cl),
  .m_pol     (m_pol),
  .shl       (shl),
  .is_master (is_master),
  .dio1_oe   (dio1_oe),
  .dio2_oe   (dio2_oe),
  .lvl_codes (lvl_codes),
  .tok       (tok)
);

// File: tb/lcs_com_scan_bench.sv
module lcs_com_scan_bench;

  localparam int N  = 64;
  localparam int CW = 2 * N;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cl = 1'b0;
  logic m_pol = 1'b0;
  logic shl = 1'b1;
  logic psel = 1'b1;
  logic fs = 1'b0;

  logic          m_d1o, m_d1e, m_d2o, m_d2e;
  logic          s_d1o, s_d1e, s_d2o, s_d2e;
  logic [CW-1:0] m_codes, s_codes;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  // Master ignores its DIO inputs, so they are held at 1.
  lcs_com_scan #(.NCOM(N)) u_lcs_com_scan (
    .clk(clk), .rst(rst), .cl(cl), .m_pol(m_pol), .shl(shl), .psel(psel),
    .is_master(1'b1), .frame_start(fs), .dio1_in(1'b1), .dio2_in(1'b1),
    .dio1_out(m_d1o), .dio1_oe(m_d1e), .dio2_out(m_d2o), .dio2_oe(m_d2e),
    .lvl_codes(m_codes)
  );

  // Slave chained behind the master; it sees frame_start too and must ignore it.
  lcs_com_scan #(.NCOM(N)) u_lcs_com_scan_slave (
    .clk(clk), .rst(rst), .cl(cl), .m_pol(m_pol), .shl(shl), .psel(psel),
    .is_master(1'b0), .frame_start(fs), .dio1_in(m_d2o), .dio2_in(m_d1o),
    .dio1_out(s_d1o), .dio1_oe(s_d1e), .dio2_out(s_d2o), .dio2_oe(s_d2e),
    .lvl_codes(s_codes)
  );

  function automatic logic [CW-1:0] expv(input int idx, input logic m);
    logic [CW-1:0] v;
    for (int i = 0; i < N; i++) begin
      v[2*i+1] = m ^ (i == idx);
      v[2*i]   = ~m;
    end
    return v;
  endfunction

  task automatic chk_vec(input string req, input logic [CW-1:0] act, input logic [CW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s codes actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_bit(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  function automatic int line_of(input int q, input logic up);
    return up ? q : (N - 1 - q);
  endfunction

  task automatic sample(input string req, input int p, input logic up, input logic m);
    int mi;
    int si;
    mi = (p < N) ? line_of(p, up) : -1;
    si = (p >= N && p < 2*N) ? line_of(p - N, up) : -1;
    chk_vec({req, " master"}, m_codes, expv(mi, m));
    chk_vec({req, " R8 slave"}, s_codes, expv(si, m));
    chk_bit("R6 master dio1_out", m_d1o, p == N - 1);
    chk_bit("R6 master dio2_out", m_d2o, p == N - 1);
    chk_bit("R8 slave carry out", up ? s_d2o : s_d1o, p == 2*N - 1);
  endtask

  task automatic run_frame(input logic up, input logic ps, input logic m, input string req);
    @(negedge clk);
    shl = up; psel = ps; m_pol = m; cl = ~ps; fs = 1'b0;
    repeat (4) @(negedge clk);
    chk_bit("R6 master dio1_oe", m_d1e, 1'b1);
    chk_bit("R6 master dio2_oe", m_d2e, 1'b1);
    chk_bit("R7 slave dio1_oe", s_d1e, ~up);
    chk_bit("R7 slave dio2_oe", s_d2e, up);
    for (int p = 0; p < 2*N + 2; p++) begin
      fs = (p == 0);
      cl = ps;
      repeat (4) @(negedge clk);
      sample({req, " R4 after active edge"}, p, up, m);
      cl = ~ps;
      fs = 1'b0;
      repeat (4) @(negedge clk);
      sample({req, " R9 after inactive edge"}, p, up, m);
    end
  endtask

  initial begin
    #1_500_000;
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk_vec("R1 reset master", m_codes, expv(-1, 1'b0));
    chk_vec("R1 reset slave", s_codes, expv(-1, 1'b0));
    chk_bit("R1 reset dio2_out", m_d2o, 1'b0);
    rst = 1'b0;
    repeat (4) @(negedge clk);

    run_frame(1'b1, 1'b1, 1'b0, "R2");
    run_frame(1'b1, 1'b0, 1'b1, "R2 R4 R5");
    run_frame(1'b0, 1'b0, 1'b0, "R3");
    run_frame(1'b0, 1'b1, 1'b1, "R3 R5");

    // R1 reset in mid-scan clears the token
    @(negedge clk);
    shl = 1'b1; psel = 1'b1; m_pol = 1'b0; cl = 1'b0;
    repeat (4) @(negedge clk);
    fs = 1'b1; cl = 1'b1;
    repeat (4) @(negedge clk);
    fs = 1'b0; cl = 1'b0;
    repeat (4) @(negedge clk);
    chk_vec("R2 token before reset", m_codes, expv(0, 1'b0));
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk_vec("R1 reset clears master", m_codes, expv(-1, 1'b0));
    chk_bit("R1 reset clears dio1_out", m_d1o, 1'b0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      cl = 1'b1;
      repeat (4) @(negedge clk);
      cl = 1'b0;
      repeat (4) @(negedge clk);
      chk_vec("R1 R9 stays empty after reset", m_codes, expv(-1, 1'b0));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule